// File: doc/BRIEF.md
# Flash Reset and Abort Sequencer

This block governs what a flash memory model does around its hardware reset pin. It watches the active-low reset pin and the chip-select, filters short reset glitches, and, once a reset is accepted, stops any running program or erase job with a one-cycle abort strobe. It forces the status byte to its reset value, blocks the data outputs, and refuses command writes. When the pin is released it counts separate recovery windows, in clock cycles, before reads and before command writes are allowed again.

The program and erase engine sits outside this block. It appears only as a `busy` input and as the lower seven status bits. Deselecting the chip never stops a running job, and the low-power standby indication stays off until the job finishes. A reset with no job running leaves the status byte at 80h. A reset that aborts a job shows 00h until recovery is over, so software can tell the two cases apart. After recovery the block is back in its normal read state.

Top module: `flash_rst_seq`

## Requirements
- R1: A low level on `rst_pin_n` seen on fewer than `T_PLPH` consecutive rising edges is ignored: `read_valid` stays 1, no abort is issued and commands are still accepted.
- R2: A reset is accepted at the rising edge that samples the `T_PLPH`-th consecutive low. From that edge onward `read_valid` and `dq_drive` are 0 and `cmd_acc` is 0.
- R3: While a reset is held or recovering and no job was running at acceptance, `status` reads 8'h80.
- R4: If `busy` is 1 at the accepting edge, `abort_pulse` is 1 for exactly the one cycle after that edge, and `status` reads 8'h00 (bit 7 clear) until recovery completes. `abort_pulse` is never raised without `busy` at the edge before.
- R5: After release, `read_valid` returns once `T_QV` rising edges have sampled `rst_pin_n` high.
- R6: After release, a command strobe is accepted (`cmd_acc`=1) after `T_WL` high samples when `cmd_via_ce`=0 (write-enable controlled), or after `T_EL` high samples when `cmd_via_ce`=1 (chip-enable controlled).
- R7: A command strobe `cmd_wr` arriving while the gate is closed is dropped (`cmd_acc`=0) and sets the sticky `cmd_err` at the next edge. Only `rst_n` clears it.
- R8: Recovery completes after max(`T_QV`,`T_WL`,`T_EL`) high samples. From then on `status` = {~busy, eng_sr[6:0]}: bit 7 is the ready flag.
- R9: `standby` is 1 only when `ce_n`=1, `busy`=0 and no reset is held or recovering. Raising `ce_n` while `busy`=1 neither aborts the job nor enters standby.
- R10: `dq_drive` = `read_valid` AND NOT `ce_n` AND NOT `oe_n`.
- R11: A low sample on `rst_pin_n` during recovery returns to the held-reset state at once, without the glitch filter, and the recovery count restarts from zero.
- R12: After `rst_n`, the block is in normal operation: `read_valid`=1, `cmd_err`=0, `abort_pulse`=0, status normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| rst_pin_n | input | 1 | Device reset pin, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| cmd_wr | input | 1 | Command write strobe |
| cmd_via_ce | input | 1 | 1: write is chip-enable controlled, 0: write-enable controlled |
| busy | input | 1 | Program/erase engine running |
| eng_sr | input | 7 | Engine status bits 6..0 |
| read_valid | output | 1 | Array data may be output |
| dq_drive | output | 1 | Data bus driven (else high impedance) |
| status | output | 8 | Status register value |
| standby | output | 1 | Low-power standby indication |
| cmd_acc | output | 1 | Current command strobe accepted |
| cmd_err | output | 1 | Sticky: a command was dropped |
| abort_pulse | output | 1 | One-cycle abort to the engine |

## Verification
Acceptance, the abort strobe and the recovery counts are registered. Their effect appears in the cycle after the rising edge that samples the pin, so the `T_PLPH`-th low or the k-th high sample shows up at that edge. `read_valid`, `dq_drive`, `status`, `standby` and `cmd_acc` are combinational from that state and from the current inputs. `cmd_err` follows one edge after the dropped strobe. Inputs change on the falling edge and every output is compared 4 ns after each rising edge against a cycle model held in the bench. Directed sequences count edges from the pin change to hit the exact first and last cycle of each window.

// File: rtl/flash_rst_pkg.sv
// Shared types and helpers for the flash reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package flash_rst_pkg;

    // Reset phase: normal, counting low samples, reset held, recovering.
    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_ARM  = 2'd1,
        PH_HOLD = 2'd2,
        PH_WAKE = 2'd3
    } rst_phase_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rst_phase_fsm.sv
// Reset phase tracker: filters reset pin glitches shorter than T_PLPH
// samples, issues the abort strobe, and counts high samples after release.
// Assumes: rst_pin_n is already synchronous to clk; all T_* >= 1.
module rst_phase_fsm
    import flash_rst_pkg::*;
#(
    parameter int T_PLPH = 4,
    parameter int T_QV   = 6,
    parameter int T_WL   = 3,
    parameter int T_EL   = 5,
    localparam int T_MAX = max3(T_QV, T_WL, T_EL),
    localparam int CW    = $clog2(((T_PLPH > T_MAX) ? T_PLPH : T_MAX) + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_pin_n,
    input  logic          busy,
    output rst_phase_t    phase,
    output logic [CW-1:0] cnt,
    output logic          abort_pulse,
    output logic          aborted
);

    logic [CW-1:0] cnt_inc;
    assign cnt_inc = cnt + CW'(1);

    // Phase transitions, sample counting and abort capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_RUN;
            cnt         <= '0;
            abort_pulse <= 1'b0;
            aborted     <= 1'b0;
        end else begin
            abort_pulse <= 1'b0;
            case (phase)
                PH_RUN, PH_ARM: begin
                    if (!rst_pin_n) begin
                        if (cnt_inc >= CW'(T_PLPH)) begin
                            phase       <= PH_HOLD;
                            cnt         <= '0;
                            abort_pulse <= busy;
                            aborted     <= busy;
                        end else begin
                            phase <= PH_ARM;
                            cnt   <= cnt_inc;
                        end
                    end else begin
                        phase <= PH_RUN;
                        cnt   <= '0;
                    end
                end
                PH_HOLD: begin
                    if (rst_pin_n) begin
                        if (T_MAX <= 1) begin
                            phase   <= PH_RUN;
                            cnt     <= '0;
                            aborted <= 1'b0;
                        end else begin
                            phase <= PH_WAKE;
                            cnt   <= CW'(1);
                        end
                    end
                end
                default: begin
                    if (!rst_pin_n) begin
                        phase <= PH_HOLD;
                        cnt   <= '0;
                    end else if (cnt_inc >= CW'(T_MAX)) begin
                        phase   <= PH_RUN;
                        cnt     <= '0;
                        aborted <= 1'b0;
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
            endcase
        end
    end

    // R4: the strobe lasts one cycle and needs a running job.
    assert_abort_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);
    assert_abort_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> $past(busy));
    // R11: a low sample during recovery returns straight to hold.
    assert_wake_relow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAKE && !rst_pin_n) |=> (phase == PH_HOLD));

endmodule

// File: rtl/rst_out_gates.sv
// Output gating: read-valid, bus drive, status byte, standby and the
// command-write gate, all decoded from the reset phase and count.
// Assumes: cnt counts high samples while phase is PH_WAKE.
module rst_out_gates
    import flash_rst_pkg::*;
#(
    parameter int T_QV = 6,
    parameter int T_WL = 3,
    parameter int T_EL = 5,
    parameter int CW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rst_phase_t    phase,
    input  logic [CW-1:0] cnt,
    input  logic          aborted,
    input  logic          busy,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          cmd_via_ce,
    input  logic [6:0]    eng_sr,
    output logic          read_valid,
    output logic          dq_drive,
    output logic [7:0]    status,
    output logic          standby,
    output logic          wr_gate
);

    logic in_rst;
    logic waking;

    // Decode gates from phase and recovery count.
    always_comb begin
        in_rst     = (phase == PH_HOLD) || (phase == PH_WAKE);
        waking     = (phase == PH_WAKE);
        read_valid = !in_rst || (waking && cnt >= CW'(T_QV));
        wr_gate    = !in_rst ||
                     (waking && cnt >= (cmd_via_ce ? CW'(T_EL) : CW'(T_WL)));
        dq_drive   = read_valid && !ce_n && !oe_n;
        standby    = ce_n && !busy && !in_rst;
        if (in_rst) status = aborted ? 8'h00 : 8'h80;
        else        status = {~busy, eng_sr};
    end

    // R3/R4: during reset the status byte is one of the two reset values.
    assert_rst_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !read_valid |-> (status == 8'h80 || status == 8'h00));
    // R10: the bus is never driven without read permission.
    assert_drive_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> read_valid);
    // R9: a running job keeps the device out of standby.
    assert_busy_awake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !standby);

endmodule

// File: rtl/cmd_guard.sv
// Command guard: passes command strobes through the write gate and records
// any strobe that was dropped in a sticky flag.
// Assumes: cmd_wr is a per-cycle strobe.
module cmd_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic wr_gate,
    output logic cmd_acc,
    output logic cmd_err
);

    assign cmd_acc = cmd_wr && wr_gate;

    // Sticky drop flag, cleared only by block reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cmd_err <= 1'b0;
        else if (cmd_wr && !wr_gate) cmd_err <= 1'b1;
    end

    // R7: the flag never clears on its own and only rises after a strobe.
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);
    assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_err) |-> $past(cmd_wr));

endmodule

// File: rtl/flash_rst_seq.sv
// Top of the flash reset sequencer: glitch filter, abort, recovery windows
// and output/command gating for a flash device model.
// Assumes: all inputs synchronous to clk; timing parameters in cycles, >= 1.
module flash_rst_seq
    import flash_rst_pkg::*;
#(
    parameter int T_PLPH = 4,
    parameter int T_QV   = 6,
    parameter int T_WL   = 3,
    parameter int T_EL   = 5,
    localparam int T_MAX = max3(T_QV, T_WL, T_EL),
    localparam int CW    = $clog2(((T_PLPH > T_MAX) ? T_PLPH : T_MAX) + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_pin_n,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       cmd_wr,
    input  logic       cmd_via_ce,
    input  logic       busy,
    input  logic [6:0] eng_sr,
    output logic       read_valid,
    output logic       dq_drive,
    output logic [7:0] status,
    output logic       standby,
    output logic       cmd_acc,
    output logic       cmd_err,
    output logic       abort_pulse
);

    rst_phase_t    phase;
    logic [CW-1:0] cnt;
    logic          aborted;
    logic          wr_gate;

    rst_phase_fsm #(.T_PLPH(T_PLPH), .T_QV(T_QV), .T_WL(T_WL), .T_EL(T_EL)) fsm_i (
        .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .busy(busy),
        .phase(phase), .cnt(cnt), .abort_pulse(abort_pulse), .aborted(aborted)
    );

    rst_out_gates #(.T_QV(T_QV), .T_WL(T_WL), .T_EL(T_EL), .CW(CW)) gates_i (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cnt(cnt), .aborted(aborted),
        .busy(busy), .ce_n(ce_n), .oe_n(oe_n), .cmd_via_ce(cmd_via_ce),
        .eng_sr(eng_sr), .read_valid(read_valid), .dq_drive(dq_drive),
        .status(status), .standby(standby), .wr_gate(wr_gate)
    );

    cmd_guard guard_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wr_gate(wr_gate),
        .cmd_acc(cmd_acc), .cmd_err(cmd_err)
    );

    // R2: once reset is accepted no command gets through.
    assert_no_cmd_in_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |-> !cmd_acc);
    // R9: deselecting the chip alone never aborts a job.
    assert_ce_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pin_n && $past(rst_pin_n) && phase == PH_RUN) |-> !abort_pulse);

endmodule

// File: tb/flash_rst_seq_tb_top.sv
// Bench: directed corner cases plus seeded random stimulus, compared every
// cycle against a cycle model written from the requirements.
module flash_rst_seq_tb_top;

    localparam int T_PLPH = 4;
    localparam int T_QV   = 6;
    localparam int T_WL   = 3;
    localparam int T_EL   = 5;
    localparam int T_MAX  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_pin_n = 1'b1;
    logic ce_n = 1'b0;
    logic oe_n = 1'b0;
    logic cmd_wr = 1'b0;
    logic cmd_via_ce = 1'b0;
    logic busy = 1'b0;
    logic [6:0] eng_sr = 7'h15;
    logic read_valid, dq_drive, standby, cmd_acc, cmd_err, abort_pulse;
    logic [7:0] status;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flash_rst_seq #(.T_PLPH(T_PLPH), .T_QV(T_QV), .T_WL(T_WL), .T_EL(T_EL)) dut_i (
        .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .ce_n(ce_n), .oe_n(oe_n),
        .cmd_wr(cmd_wr), .cmd_via_ce(cmd_via_ce), .busy(busy), .eng_sr(eng_sr),
        .read_valid(read_valid), .dq_drive(dq_drive), .status(status),
        .standby(standby), .cmd_acc(cmd_acc), .cmd_err(cmd_err),
        .abort_pulse(abort_pulse)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Cycle model of the requirements.
    bit m_rst = 0, m_hold = 0, m_abt = 0, m_err = 0, m_pulse = 0;
    int low_run = 0, m_high = 0;

    function automatic bit exp_gate(input bit via_ce);
        return !m_rst || (!m_hold && m_high >= (via_ce ? T_EL : T_WL));
    endfunction
    function automatic bit exp_rv();
        return !m_rst || (!m_hold && m_high >= T_QV);
    endfunction
    function automatic logic [7:0] exp_status(input bit bz, input logic [6:0] sr);
        if (m_rst) return m_abt ? 8'h00 : 8'h80;
        return {~bz, sr};
    endfunction

    // Advance the model at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rst = 0; m_hold = 0; m_abt = 0; m_err = 0; m_pulse = 0;
            low_run = 0; m_high = 0;
        end else begin
            if (cmd_wr && !exp_gate(cmd_via_ce)) m_err = 1;
            m_pulse = 0;
            if (!m_rst) begin
                if (!rst_pin_n) begin
                    low_run++;
                    if (low_run >= T_PLPH) begin
                        m_rst = 1; m_hold = 1; m_abt = busy; m_pulse = busy; low_run = 0;
                    end
                end else low_run = 0;
            end else if (!rst_pin_n) begin
                m_hold = 1; m_high = 0;
            end else begin
                m_hold = 0; m_high++;
                if (m_high >= T_MAX) begin m_rst = 0; m_abt = 0; m_high = 0; end
            end
        end
    end

    // Compare every output 4 ns after each rising edge.
    always @(posedge clk) begin
        #4;
        if (rst_n && !done) begin
            chk("R2/R5 read_valid", {7'd0, read_valid}, {7'd0, exp_rv()});
            chk("R10 dq_drive", {7'd0, dq_drive}, {7'd0, exp_rv() && !ce_n && !oe_n});
            chk("R3/R4/R8 status", status, exp_status(busy, eng_sr));
            chk("R9 standby", {7'd0, standby}, {7'd0, ce_n && !busy && !m_rst});
            chk("R6 cmd_acc", {7'd0, cmd_acc}, {7'd0, cmd_wr && exp_gate(cmd_via_ce)});
            chk("R7 cmd_err", {7'd0, cmd_err}, {7'd0, m_err});
            chk("R4 abort_pulse", {7'd0, abort_pulse}, {7'd0, m_pulse});
        end
    end

    task automatic after_edge();
        @(posedge clk); #5;
    endtask

    task automatic block_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        block_reset();
        after_edge();
        // R12: normal state after block reset.
        chk("R12 read_valid", {7'd0, read_valid}, 8'd1);
        chk("R12 cmd_err", {7'd0, cmd_err}, 8'd0);
        chk("R12 status", status, 8'h95);

        // R1: glitch one sample short of the filter.
        @(negedge clk); rst_pin_n = 0; cmd_wr = 1;
        for (int i = 1; i < T_PLPH; i++) begin
            after_edge();
            chk("R1 glitch read_valid", {7'd0, read_valid}, 8'd1);
            chk("R1 glitch cmd_acc", {7'd0, cmd_acc}, 8'd1);
        end
        @(negedge clk); rst_pin_n = 1; cmd_wr = 0;
        after_edge();
        chk("R1 no abort", {7'd0, abort_pulse}, 8'd0);

        // R2/R4: full-length reset while a job runs.
        @(negedge clk); rst_pin_n = 0; busy = 1;
        for (int i = 1; i <= T_PLPH; i++) begin
            after_edge();
            chk("R2 accept edge read_valid", {7'd0, read_valid}, (i < T_PLPH) ? 8'd1 : 8'd0);
        end
        chk("R4 abort strobe", {7'd0, abort_pulse}, 8'd1);
        chk("R4 aborted status", status, 8'h00);
        @(negedge clk); busy = 0;
        after_edge();
        chk("R4 strobe single", {7'd0, abort_pulse}, 8'd0);

        // R5/R6/R7/R8: release with a command strobe held through recovery.
        @(negedge clk); rst_pin_n = 1; cmd_wr = 1; cmd_via_ce = 0;
        for (int i = 1; i <= T_MAX; i++) begin
            after_edge();
            chk("R5 read_valid window", {7'd0, read_valid}, (i >= T_QV) ? 8'd1 : 8'd0);
            chk("R6 write-enable window", {7'd0, cmd_acc}, (i >= T_WL) ? 8'd1 : 8'd0);
            chk("R8 status", status, (i >= T_MAX) ? 8'h95 : 8'h00);
        end
        @(negedge clk); cmd_wr = 0;
        after_edge();
        chk("R7 sticky err", {7'd0, cmd_err}, 8'd1);
        block_reset();
        after_edge();
        chk("R7 err cleared by rst_n", {7'd0, cmd_err}, 8'd0);

        // R3/R6/R11: idle reset, chip-enable controlled window, relow in recovery.
        @(negedge clk); rst_pin_n = 0;
        repeat (T_PLPH) after_edge();
        chk("R3 idle reset status", status, 8'h80);
        @(negedge clk); rst_pin_n = 1;
        repeat (2) after_edge();
        @(negedge clk); rst_pin_n = 0;
        after_edge();
        @(negedge clk); rst_pin_n = 1; cmd_wr = 1; cmd_via_ce = 1;
        for (int i = 1; i <= T_EL; i++) begin
            after_edge();
            chk("R11/R6 chip-enable window", {7'd0, cmd_acc}, (i >= T_EL) ? 8'd1 : 8'd0);
        end
        @(negedge clk); cmd_wr = 0; cmd_via_ce = 0;
        repeat (3) after_edge();

        // R9: deselect during a job.
        @(negedge clk); ce_n = 1; busy = 1;
        after_edge();
        chk("R9 busy standby", {7'd0, standby}, 8'd0);
        chk("R9 no abort", {7'd0, abort_pulse}, 8'd0);
        @(negedge clk); busy = 0;
        after_edge();
        chk("R9 standby", {7'd0, standby}, 8'd1);

        // Random phase.
        block_reset();
        begin
            int run = 0;
            for (int c = 0; c < 4000; c++) begin
                @(negedge clk);
                if (run == 0) begin
                    rst_pin_n = ($urandom % 4) != 0;
                    run = rst_pin_n ? 5 + int'($urandom % 25) : 1 + int'($urandom % 8);
                end
                run--;
                if ($urandom % 10 == 0) busy = ~busy;
                ce_n = ($urandom % 3) == 0;
                oe_n = ($urandom % 4) == 0;
                cmd_wr = ($urandom % 5) == 0;
                cmd_via_ce = $urandom % 2;
                eng_sr = 7'($urandom);
                if (c == 2000) rst_n = 0;
                if (c == 2003) rst_n = 1;
            end
        end
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule